// File: doc/BRIEF.md
# Shadowed Overlay Window Position and Update Unit

This block keeps the placement and buffer description of a small set of stacked overlay windows. Software writes every window field into a shadow copy through a simple register write port. The display pipeline sees only the active copy, and that copy changes only at a frame start, after an update has been requested and while protect is clear. Software can therefore rewrite a whole frame's worth of window settings, including rectangles, buffer addresses, line geometry and enables, and have them take effect together on one frame boundary. A frame that begins halfway through a sequence of writes never mixes old and new values.

From the active copy the block also decides, for the pixel position presented on its inputs, which window is on top there. Each window covers an inclusive rectangle. Among the enabled windows that contain the pixel, the one with the highest index wins. The result is registered and appears one clock after the position. The fetch engine and the blender downstream use the active outputs and the selected index. The block itself does neither fetch nor blending.

Top module: `overlay_win_shadow`

## Requirements
- R1: When several enabled windows contain the pixel, `sel_win` reports the highest window index among them. Window 0 is lowest in z-order and window NWIN-1 is highest.
- R2: A coordinate word carries X in bits 23:12 and Y in bits 11:0. `act_start` and `act_end` present each window's word with that same packing, 24 bits per window, with window w at bits 24w+23:24w.
- R3: The end coordinate is inclusive. A pixel with x equal to end X, or y equal to end Y, is inside the window. x = end X + 1 or y = end Y + 1 is outside it.
- R4: While protect (bit 0 at address 8*NWIN) is set at a frame start, no shadow value reaches the active outputs. Writes made during that time change only the shadow copy.
- R5: Writing 1 to bit 0 at address 8*NWIN+1 raises `upd_pending`. Writing 0 there has no effect. At the next `frame_start` with protect clear, all shadow fields of all windows are copied to the active outputs, visible one clock later, and `upd_pending` clears in the same clock. The active outputs change at no other time.
- R6: A pending update survives any number of frame starts that occur while protect is set. It is applied at the first frame start with protect clear.
- R7: Bit 0 of a window's control word is its enable and appears on `act_en`. A disabled window is never selected, even where its rectangle contains the pixel.
- R8: The size word carries the line offset in bits 27:14 and the visible byte count in bits 13:0. These appear separately on `act_line_off` and `act_line_bytes`, 14 bits per window.
- R9: Window w occupies addresses 8w to 8w+5: start coordinate, end coordinate, buffer start address, buffer end address, size word and control word. Both addresses are 32 bits wide and are copied unchanged to `act_base` and `act_limit`.
- R10: After reset, all active fields and enables are zero, protect and `upd_pending` are clear, and `sel_hit` is 0.
- R11: `sel_hit` and `sel_win` are registered. They reflect the `pix_x`/`pix_y` sampled at the previous clock edge against the active copy held at that edge. When no window covers the pixel, `sel_hit` is 0 and `sel_win` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address (window group in bits 4:3, field in bits 2:0) |
| wr_data | input | 32 | Register write data |
| frame_start | input | 1 | One-cycle frame boundary pulse |
| pix_x | input | 12 | Current pixel column |
| pix_y | input | 12 | Current pixel row |
| upd_pending | output | 1 | Update requested but not yet applied |
| act_en | output | 3 | Active enable per window |
| act_start | output | 72 | Active start coordinate words |
| act_end | output | 72 | Active inclusive end coordinate words |
| act_base | output | 96 | Active buffer start addresses |
| act_limit | output | 96 | Active buffer end addresses |
| act_line_off | output | 42 | Active line offset per window |
| act_line_bytes | output | 42 | Active visible byte count per window |
| sel_hit | output | 1 | Some enabled window covers the pixel |
| sel_win | output | 2 | Index of the topmost covering window |

## Verification
The bench builds the block with its defaults: three windows, 12-bit coordinates, 32-bit addresses and 14-bit size fields, with a registered select. With three windows it can nest rectangles so that every level of the priority chain decides some pixel. With 12-bit coordinates it can place a window corner at 4095,4095, which exercises the top bit of both packed fields. It holds protect over two frame starts to show that a request survives them, and it sweeps pixels across all rectangle edges while a behavioural model follows every clock.

// File: rtl/ows_pkg.sv
package ows_pkg;

   localparam int FIELD_BITS = 3;

   typedef enum logic [FIELD_BITS-1:0] {
      FLD_START = 3'd0,
      FLD_END   = 3'd1,
      FLD_BASE  = 3'd2,
      FLD_LIMIT = 3'd3,
      FLD_SIZE  = 3'd4,
      FLD_CTRL  = 3'd5
   } wfield_e;

   localparam logic [FIELD_BITS-1:0] GLB_PROTECT = 3'd0;
   localparam logic [FIELD_BITS-1:0] GLB_UPDATE  = 3'd1;

endpackage

// File: rtl/ows_slot.sv
module ows_slot
   import ows_pkg::*;
#(
   parameter int CW  = 12,
   parameter int AW  = 32,
   parameter int SZW = 14,
   parameter int DW  = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [FIELD_BITS-1:0] wr_field,
   input  logic [DW-1:0]         wr_data,
   input  logic                  commit,
   output logic [2*CW-1:0]       act_start,
   output logic [2*CW-1:0]       act_end,
   output logic [AW-1:0]         act_base,
   output logic [AW-1:0]         act_limit,
   output logic [2*SZW-1:0]      act_size,
   output logic                  act_en
);
   localparam int PW = 2*CW;
   localparam int SW = 2*SZW;

   logic [PW-1:0] sh_start, sh_end;
   logic [AW-1:0] sh_base, sh_limit;
   logic [SW-1:0] sh_size;
   logic          sh_en;
   logic          unused_wdata;

   assign unused_wdata = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_start <= '0;
         sh_end   <= '0;
         sh_base  <= '0;
         sh_limit <= '0;
         sh_size  <= '0;
         sh_en    <= 1'b0;
      end else if (wr_en) begin
         case (wfield_e'(wr_field))
            FLD_START: sh_start <= wr_data[PW-1:0];
            FLD_END:   sh_end   <= wr_data[PW-1:0];
            FLD_BASE:  sh_base  <= wr_data[AW-1:0];
            FLD_LIMIT: sh_limit <= wr_data[AW-1:0];
            FLD_SIZE:  sh_size  <= wr_data[SW-1:0];
            FLD_CTRL:  sh_en    <= wr_data[0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_start <= '0;
         act_end   <= '0;
         act_base  <= '0;
         act_limit <= '0;
         act_size  <= '0;
         act_en    <= 1'b0;
      end else if (commit) begin
         act_start <= sh_start;
         act_end   <= sh_end;
         act_base  <= sh_base;
         act_limit <= sh_limit;
         act_size  <= sh_size;
         act_en    <= sh_en;
      end
   end

endmodule

// File: rtl/ows_cover.sv
module ows_cover #(
   parameter int CW = 12
) (
   input  logic [CW-1:0]   px,
   input  logic [CW-1:0]   py,
   input  logic [2*CW-1:0] start_w,
   input  logic [2*CW-1:0] end_w,
   input  logic            en,
   output logic            hit
);
   logic [CW-1:0] sx, sy, ex, ey;
   logic          in_x, in_y;

   assign sx = start_w[2*CW-1:CW];
   assign sy = start_w[CW-1:0];
   assign ex = end_w[2*CW-1:CW];
   assign ey = end_w[CW-1:0];

   assign in_x = (px >= sx) && (px <= ex);
   assign in_y = (py >= sy) && (py <= ey);
   assign hit  = en && in_x && in_y;

endmodule

// File: rtl/ows_pick.sv
module ows_pick #(
   parameter int NWIN    = 3,
   parameter bit OUT_REG = 1'b1,
   localparam int IW     = (NWIN > 1) ? $clog2(NWIN) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NWIN-1:0] hit_vec,
   input  logic [NWIN-1:0] en_vec,
   output logic            sel_hit,
   output logic [IW-1:0]   sel_win
);
   logic          any_c;
   logic [IW-1:0] idx_c;

   always_comb begin
      any_c = 1'b0;
      idx_c = '0;
      for (int w = 0; w < NWIN; w++) begin
         if (hit_vec[w]) begin
            any_c = 1'b1;
            idx_c = IW'(w);
         end
      end
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sel_hit <= 1'b0;
               sel_win <= '0;
            end else begin
               sel_hit <= any_c;
               sel_win <= idx_c;
            end
         end

         // R7: a reported window was enabled when the pixel was sampled
         a_r7_sel_enabled: assert property (@(posedge clk) disable iff (!rst_n)
            sel_hit |-> ((($past(en_vec) >> sel_win) & NWIN'(1)) != '0))
            else $error("selected window was disabled");

         // R1: nothing above the reported window covered the pixel
         a_r1_no_higher_hit: assert property (@(posedge clk) disable iff (!rst_n)
            sel_hit |-> ((($past(hit_vec) >> sel_win) >> 1) == '0))
            else $error("higher window was skipped");

         // R11: an empty cover vector yields no selection and index 0
         a_r11_none_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_vec == '0) |=> (!sel_hit && sel_win == '0))
            else $error("selection without cover");
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n ^ (^en_vec);
         assign sel_hit = any_c;
         assign sel_win = idx_c;
      end
   endgenerate

endmodule

// File: rtl/overlay_win_shadow.sv
module overlay_win_shadow
   import ows_pkg::*;
#(
   parameter int NWIN    = 3,
   parameter int CW      = 12,
   parameter int AW      = 32,
   parameter int SZW     = 14,
   parameter int DW      = 32,
   parameter int RAW     = 5,
   parameter bit OUT_REG = 1'b1,
   localparam int PW     = 2*CW,
   localparam int SW     = 2*SZW,
   localparam int IW     = (NWIN > 1) ? $clog2(NWIN) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [RAW-1:0]     wr_addr,
   input  logic [DW-1:0]      wr_data,
   input  logic               frame_start,
   input  logic [CW-1:0]      pix_x,
   input  logic [CW-1:0]      pix_y,
   output logic               upd_pending,
   output logic [NWIN-1:0]    act_en,
   output logic [NWIN*PW-1:0] act_start,
   output logic [NWIN*PW-1:0] act_end,
   output logic [NWIN*AW-1:0] act_base,
   output logic [NWIN*AW-1:0] act_limit,
   output logic [NWIN*SZW-1:0] act_line_off,
   output logic [NWIN*SZW-1:0] act_line_bytes,
   output logic               sel_hit,
   output logic [IW-1:0]      sel_win
);
   localparam int GW = RAW - FIELD_BITS;

   initial begin
      assert (GW >= 1 && NWIN >= 1 && NWIN < (1 << GW))
         else $error("address space too small for NWIN windows plus global group");
      assert (PW <= DW && AW <= DW && SW <= DW)
         else $error("field wider than the write data bus");
   end

   logic [GW-1:0]         grp;
   logic [FIELD_BITS-1:0] fld;
   logic                  glb_wr, req_set, commit;
   logic                  prot_q, pend_q;
   logic [NWIN-1:0]       hit_vec;

   assign grp     = wr_addr[RAW-1:FIELD_BITS];
   assign fld     = wr_addr[FIELD_BITS-1:0];
   assign glb_wr  = wr_en && (grp == GW'(NWIN));
   assign req_set = glb_wr && (fld == GLB_UPDATE) && wr_data[0];
   assign commit  = frame_start && pend_q && !prot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (glb_wr && fld == GLB_PROTECT)
            prot_q <= wr_data[0];
         pend_q <= req_set || (pend_q && !commit);
      end
   end

   assign upd_pending = pend_q;

   generate
      for (genvar w = 0; w < NWIN; w++) begin : g_win
         logic [PW-1:0] st_w, en_w;
         logic [SW-1:0] sz_w;

         ows_slot #(.CW(CW), .AW(AW), .SZW(SZW), .DW(DW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en && (grp == GW'(w))),
            .wr_field  (fld),
            .wr_data   (wr_data),
            .commit    (commit),
            .act_start (st_w),
            .act_end   (en_w),
            .act_base  (act_base[w*AW +: AW]),
            .act_limit (act_limit[w*AW +: AW]),
            .act_size  (sz_w),
            .act_en    (act_en[w])
         );

         ows_cover #(.CW(CW)) u_cover (
            .px      (pix_x),
            .py      (pix_y),
            .start_w (st_w),
            .end_w   (en_w),
            .en      (act_en[w]),
            .hit     (hit_vec[w])
         );

         assign act_start[w*PW +: PW]        = st_w;
         assign act_end[w*PW +: PW]          = en_w;
         assign act_line_off[w*SZW +: SZW]   = sz_w[SW-1:SZW];
         assign act_line_bytes[w*SZW +: SZW] = sz_w[SZW-1:0];
      end
   endgenerate

   ows_pick #(.NWIN(NWIN), .OUT_REG(OUT_REG)) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_vec (hit_vec),
      .en_vec  (act_en),
      .sel_hit (sel_hit),
      .sel_win (sel_win)
   );

   // R4: a protected frame start leaves the active copy untouched
   a_r4_protect_holds_active: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && prot_q) |=> ($stable(act_en) && $stable(act_start) && $stable(act_end)
                                   && $stable(act_base) && $stable(act_limit)))
      else $error("active copy changed under protect");

   // R5: the active copy moves only on a frame start
   a_r5_quiet_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> ($stable(act_en) && $stable(act_start) && $stable(act_end)
                        && $stable(act_line_off) && $stable(act_line_bytes)))
      else $error("active copy changed without frame start");

   // R5: an honoured request clears itself
   a_r5_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && pend_q && !prot_q && !req_set) |=> !upd_pending)
      else $error("update request did not self-clear");

   // R6: protect keeps a request waiting
   a_r6_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && prot_q) |=> upd_pending)
      else $error("pending request lost under protect");

endmodule

// File: tb/overlay_win_shadow_bench.sv
module overlay_win_shadow_bench;
   localparam int NW = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        frame_start = 1'b0;
   logic [11:0] pix_x = '0;
   logic [11:0] pix_y = '0;
   logic        upd_pending;
   logic [2:0]  act_en;
   logic [71:0] act_start, act_end;
   logic [95:0] act_base, act_limit;
   logic [41:0] act_line_off, act_line_bytes;
   logic        sel_hit;
   logic [1:0]  sel_win;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   overlay_win_shadow u_overlay_win_shadow (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .frame_start(frame_start), .pix_x(pix_x), .pix_y(pix_y),
      .upd_pending(upd_pending), .act_en(act_en), .act_start(act_start), .act_end(act_end),
      .act_base(act_base), .act_limit(act_limit), .act_line_off(act_line_off),
      .act_line_bytes(act_line_bytes), .sel_hit(sel_hit), .sel_win(sel_win)
   );

   // behavioural reference: field 0 start, 1 end, 2 base, 3 limit, 4 size, 5 ctrl
   logic [31:0] m_sh  [NW][6];
   logic [31:0] m_act [NW][6];
   logic        m_prot, m_pend, m_hit;
   logic [1:0]  m_win;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < NW; w++)
            for (int f = 0; f < 6; f++) begin
               m_sh[w][f]  <= 32'd0;
               m_act[w][f] <= 32'd0;
            end
         m_prot <= 1'b0; m_pend <= 1'b0; m_hit <= 1'b0; m_win <= 2'd0;
      end else begin
         bit go, req, h;
         int top;
         go  = frame_start && m_pend && !m_prot;
         req = 1'b0;
         top = -1;
         for (int w = 0; w < NW; w++) begin
            h = m_act[w][5][0] &&
                pix_x >= m_act[w][0][23:12] && pix_x <= m_act[w][1][23:12] &&
                pix_y >= m_act[w][0][11:0]  && pix_y <= m_act[w][1][11:0];
            if (h) top = w;
         end
         m_hit <= (top >= 0);
         m_win <= (top >= 0) ? 2'(top) : 2'd0;
         if (go)
            for (int w = 0; w < NW; w++)
               for (int f = 0; f < 6; f++) m_act[w][f] <= m_sh[w][f];
         if (wr_en) begin
            if (wr_addr[4:3] < 2'd3 && wr_addr[2:0] < 3'd6)
               m_sh[wr_addr[4:3]][wr_addr[2:0]] <= wr_data;
            else if (wr_addr == 5'd24) m_prot <= wr_data[0];
            else if (wr_addr == 5'd25 && wr_data[0]) req = 1'b1;
         end
         m_pend <= (m_pend && !go) || req;
      end
   end

   task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R5", "pending vs model", 64'(upd_pending), 64'(m_pend));
         for (int w = 0; w < NW; w++) begin
            chk("R7", "enable vs model", 64'(act_en[w]), 64'(m_act[w][5][0]));
            chk("R2", "start vs model", 64'(act_start[w*24 +: 24]), 64'(m_act[w][0][23:0]));
            chk("R3", "end vs model", 64'(act_end[w*24 +: 24]), 64'(m_act[w][1][23:0]));
            chk("R9", "base vs model", 64'(act_base[w*32 +: 32]), 64'(m_act[w][2]));
            chk("R9", "limit vs model", 64'(act_limit[w*32 +: 32]), 64'(m_act[w][3]));
            chk("R8", "offset vs model", 64'(act_line_off[w*14 +: 14]), 64'(m_act[w][4][27:14]));
            chk("R8", "bytes vs model", 64'(act_line_bytes[w*14 +: 14]), 64'(m_act[w][4][13:0]));
         end
         chk("R11", "sel_hit vs model", 64'(sel_hit), 64'(m_hit));
         chk("R1", "sel_win vs model", 64'(sel_win), 64'(m_win));
      end
   end

   task automatic wreg(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_win(input int w, input int sx, input int sy, input int ex, input int ey, input bit en);
      wreg(5'(w*8 + 0), 32'((sx << 12) | sy));
      wreg(5'(w*8 + 1), 32'((ex << 12) | ey));
      wreg(5'(w*8 + 5), 32'(en));
   endtask

   task automatic frame();
      @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
   endtask

   task automatic probe(input int x, input int y, input bit eh, input int ew, input string req);
      @(negedge clk);
      pix_x = 12'(x); pix_y = 12'(y);
      @(negedge clk);
      chk(req, "directed sel_hit", 64'(sel_hit), 64'(eh));
      chk(req, "directed sel_win", 64'(sel_win), 64'(ew));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "reset enables", 64'(act_en), 64'd0);
      chk("R10", "reset pending", 64'(upd_pending), 64'd0);
      chk("R10", "reset sel_hit", 64'(sel_hit), 64'd0);
      chk("R10", "reset start", 64'(act_start), 64'd0);

      set_win(0, 0, 0, 99, 79, 1'b1);
      set_win(1, 10, 10, 49, 29, 1'b1);
      set_win(2, 40, 20, 59, 39, 1'b1);
      wreg(5'd2, 32'h1000_0000);
      wreg(5'd3, 32'h1000_3E80);
      wreg(5'd25, 32'd0);
      chk("R5", "write of 0 ignored", 64'(upd_pending), 64'd0);
      frame();
      chk("R5", "no copy without request", 64'(act_en), 64'd0);
      wreg(5'd25, 32'd1);
      chk("R5", "request raised", 64'(upd_pending), 64'd1);
      probe(45, 25, 1'b0, 0, "R5");
      frame();
      chk("R5", "copy applied", 64'(act_en), 64'h7);
      chk("R5", "request self-cleared", 64'(upd_pending), 64'd0);
      chk("R9", "base copied", 64'(act_base[31:0]), 64'h1000_0000);
      chk("R2", "end word packing win2", 64'(act_end[71:48]), 64'h03B027);

      probe(45, 25, 1'b1, 2, "R1");
      probe(20, 15, 1'b1, 1, "R1");
      probe(59, 39, 1'b1, 2, "R3");
      probe(60, 39, 1'b1, 0, "R3");
      probe(45, 40, 1'b1, 0, "R3");
      probe(99, 79, 1'b1, 0, "R3");
      probe(100, 0, 1'b0, 0, "R11");
      probe(0, 80, 1'b0, 0, "R11");

      wreg(5'd24, 32'd1);
      wreg(5'd21, 32'd0);
      wreg(5'd25, 32'd1);
      frame();
      chk("R4", "protected frame keeps enables", 64'(act_en), 64'h7);
      chk("R6", "pending kept under protect", 64'(upd_pending), 64'd1);
      probe(45, 25, 1'b1, 2, "R4");
      frame();
      chk("R6", "pending kept second frame", 64'(upd_pending), 64'd1);
      wreg(5'd24, 32'd0);
      chk("R4", "protect release alone copies nothing", 64'(act_en), 64'h7);
      frame();
      chk("R6", "deferred copy applied", 64'(act_en), 64'h3);
      chk("R6", "pending cleared", 64'(upd_pending), 64'd0);
      probe(45, 25, 1'b1, 1, "R7");
      probe(55, 35, 1'b1, 0, "R7");

      wreg(5'd4, 32'((12'h123 << 14) | 14'h2A5));
      wreg(5'd1, 32'((4095 << 12) | 4095));
      wreg(5'd25, 32'd1);
      frame();
      chk("R8", "line offset field", 64'(act_line_off[13:0]), 64'h123);
      chk("R8", "visible bytes field", 64'(act_line_bytes[13:0]), 64'h2A5);
      chk("R2", "max corner packing", 64'(act_end[23:0]), 64'hFFFFFF);
      probe(4095, 4095, 1'b1, 0, "R2");
      probe(4095, 0, 1'b1, 0, "R2");

      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         pix_x = 12'((i * 7) % 112);
         pix_y = 12'((i * 13) % 90);
         if (i == 150) begin
            wr_en = 1'b1; wr_addr = 5'd21; wr_data = 32'd1;
         end else if (i == 151) begin
            wr_addr = 5'd25; wr_data = 32'd1; frame_start = 1'b1;
         end else begin
            wr_en = 1'b0; frame_start = (i == 200);
         end
      end
      @(negedge clk);
      frame_start = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1", "late re-enable of top window", 64'(act_en), 64'h7);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got hang expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule